// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block turns an asynchronous serial line into parallel characters. A receive clock, given as a single-cycle enable pulse in the system clock domain, paces the line sampling. An eight-bit mode word controls sampling. It selects a rate factor of 1x, 16x or 64x receive-clock ticks per bit, a character length of 5 to 8 data bits, and an optional odd or even parity bit. The transmitter beside this block decodes the same word with the same field positions.

Each completed character goes into a one-entry buffer and raises a ready flag. The ready flag stays up until the host pulses a read strobe. Parity, framing and overrun problems set three separate flags. These flags survive reads, and only an explicit clear pulse from the command logic resets them. A receive-enable input must be high for any reception to take place.

Top module: `serial_rx_core`

## Requirements
- R1: After a synchronous active-high `rst`, `rx_ready`, `parity_err`, `frame_err`, `overrun_err` and `rx_data` are all 0.
- R2: Data bits arrive least significant bit first. `mode[3:2]` selects the length: 00=5, 01=6, 10=7 or 11=8 bits. A shorter character sits in the low bits of `rx_data`, and the upper bits read 0.
- R3: When `mode[1:0]` is 10 (16 ticks per bit) or 11 (64 ticks per bit), a low `rxd` seen on an idle tick starts a candidate start bit. Half a bit time later the line is sampled again. If it is high, the candidate is dropped and the receiver goes back to idle. If it is low, each following bit is sampled one full bit time after the previous sample.
- R4: When `mode[1:0]` is 01 (or 00, which is treated the same way), the tick that first sees `rxd` low is taken as the start bit. Every later tick samples one bit.
- R5: `rx_ready` goes high on the clock edge that ends the tick sampling the first stop bit, and `rx_data` is loaded on that same edge. `rx_ready` then stays high until it is read.
- R6: A one-cycle `rd_strobe` clears `rx_ready`. It leaves `rx_data` and all error flags unchanged.
- R7: When `mode[4]` is 1, one parity bit follows the data bits. `mode[5]`=1 selects even parity and 0 selects odd parity. A mismatch sets `parity_err` when the character completes.
- R8: A first stop bit sampled as 0 sets `frame_err`. The character is still stored and flagged ready.
- R9: If a character completes while `rx_ready` is high and no read happens in that cycle, `overrun_err` is set and the new character replaces the old one.
- R10: The three error flags are sticky. A one-cycle `err_clear` resets all of them, but a flag set by a character completing in the same cycle still wins.
- R11: While `rx_enable` is 0, no character is received and any partial character is dropped. `rx_data` and `rx_ready` do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rxc_en | input | 1 | Receive clock tick, one cycle wide |
| rxd | input | 1 | Serial data line, idle high |
| mode | input | 8 | Mode word: rate [1:0], length [3:2], parity enable [4], even parity [5] |
| rx_enable | input | 1 | Receiver enable |
| err_clear | input | 1 | Pulse that clears all error flags |
| rd_strobe | input | 1 | Pulse that marks the host reading the buffer |
| rx_data | output | 8 | Received character, zero padded |
| rx_ready | output | 1 | Character available |
| parity_err | output | 1 | Sticky parity error |
| frame_err | output | 1 | Sticky framing error |
| overrun_err | output | 1 | Sticky overrun error |

## Verification
The properties assume that `rd_strobe` and `err_clear` are single-cycle pulses. They also assume that `mode` is held constant while a character is in flight, because the bit counters and the parity check read it every tick. The stimulus changes `mode` only while the line has been idle for several bit times. It changes each serial bit on the falling clock edge just after a tick, so every midpoint sample lands well inside its bit. The glitch case keeps the line low for fewer ticks than half a bit, which exercises the start-bit rejection path.

// File: rtl/serial_rx_core.sv
module serial_rx_core (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxc_en,
  input  logic       rxd,
  input  logic [7:0] mode,
  input  logic       rx_enable,
  input  logic       err_clear,
  input  logic       rd_strobe,
  output logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       parity_err,
  output logic       frame_err,
  output logic       overrun_err
);
  localparam int CNT_W = 7;

  typedef enum logic [2:0] {IDLE, START, DATA, PAR, STOP} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] div;
  logic [2:0]       idx;
  logic [7:0]       shreg;
  logic             par_acc;
  logic             par_bad;

  always_comb begin
    case (mode[1:0])
      2'b10:   div = CNT_W'(16);
      2'b11:   div = CNT_W'(64);
      default: div = CNT_W'(1);
    endcase
  end

  wire       oversample = mode[1];
  wire [2:0] last_idx   = {1'b1, mode[3:2]};
  wire       sample     = rxc_en && (cnt == div);
  wire       done       = rx_enable && (st == STOP) && sample;

  always_ff @(posedge clk) begin
    if (rst || !rx_enable) begin
      st      <= IDLE;
      cnt     <= CNT_W'(1);
      idx     <= '0;
      shreg   <= '0;
      par_acc <= 1'b0;
      par_bad <= 1'b0;
    end else if (rxc_en) begin
      cnt <= (cnt == div) ? CNT_W'(1) : cnt + CNT_W'(1);
      case (st)
        IDLE: begin
          cnt <= CNT_W'(1);
          if (!rxd) begin
            st      <= oversample ? START : DATA;
            idx     <= '0;
            shreg   <= '0;
            par_acc <= 1'b0;
            par_bad <= 1'b0;
          end
        end
        START: if (cnt == (div >> 1)) begin
          cnt <= CNT_W'(1);
          st  <= rxd ? IDLE : DATA;
        end
        DATA: if (sample) begin
          shreg[idx] <= rxd;
          par_acc    <= par_acc ^ rxd;
          if (idx == last_idx) st <= mode[4] ? PAR : STOP;
          else                 idx <= idx + 3'd1;
        end
        PAR: if (sample) begin
          par_bad <= ((par_acc ^ rxd) == mode[5]);
          st      <= STOP;
        end
        STOP: if (sample) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data     <= '0;
      rx_ready    <= 1'b0;
      parity_err  <= 1'b0;
      frame_err   <= 1'b0;
      overrun_err <= 1'b0;
    end else begin
      if (done) begin
        rx_data  <= shreg;
        rx_ready <= 1'b1;
      end else if (rd_strobe) begin
        rx_ready <= 1'b0;
      end
      parity_err  <= (parity_err  & ~err_clear) | (done & par_bad);
      frame_err   <= (frame_err   & ~err_clear) | (done & ~rxd);
      overrun_err <= (overrun_err & ~err_clear) | (done & rx_ready & ~rd_strobe);
    end
  end
endmodule

module serial_rx_core_chk (
  input logic       clk,
  input logic       rst,
  input logic       rx_enable,
  input logic       rd_strobe,
  input logic       err_clear,
  input logic       done,
  input logic [7:0] rx_data,
  input logic       rx_ready,
  input logic       parity_err,
  input logic       frame_err,
  input logic       overrun_err
);
  a_r5_done_sets_ready: assert property (@(posedge clk) disable iff (rst)
    done |=> rx_ready);
  a_r5_ready_holds: assert property (@(posedge clk) disable iff (rst)
    rx_ready && !rd_strobe |=> rx_ready);
  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
    rd_strobe && !done |=> !rx_ready);
  a_r9_overrun_sets: assert property (@(posedge clk) disable iff (rst)
    done && rx_ready && !rd_strobe |=> overrun_err);
  a_r10_pe_sticky: assert property (@(posedge clk) disable iff (rst)
    parity_err && !err_clear |=> parity_err);
  a_r10_fe_sticky: assert property (@(posedge clk) disable iff (rst)
    frame_err && !err_clear |=> frame_err);
  a_r10_oe_sticky: assert property (@(posedge clk) disable iff (rst)
    overrun_err && !err_clear |=> overrun_err);
  a_r10_clear_all: assert property (@(posedge clk) disable iff (rst)
    err_clear && !done |=> !parity_err && !frame_err && !overrun_err);
  a_r11_no_load: assert property (@(posedge clk) disable iff (rst)
    !rx_enable |=> $stable(rx_data) && !$rose(rx_ready));
endmodule

bind serial_rx_core serial_rx_core_chk u_chk (
  .clk(clk), .rst(rst), .rx_enable(rx_enable), .rd_strobe(rd_strobe),
  .err_clear(err_clear), .done(done), .rx_data(rx_data), .rx_ready(rx_ready),
  .parity_err(parity_err), .frame_err(frame_err), .overrun_err(overrun_err)
);

// File: tb/serial_rx_core_test.sv
module serial_rx_core_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxc_en = 1'b0;
  logic       rxd = 1'b1;
  logic [7:0] mode = 8'hCE;
  logic       rx_enable = 1'b0;
  logic       err_clear = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready, parity_err, frame_err, overrun_err;

  int checks = 0;
  int fails  = 0;
  int tick_div = 0;

  serial_rx_core uut (
    .clk(clk), .rst(rst), .rxc_en(rxc_en), .rxd(rxd), .mode(mode),
    .rx_enable(rx_enable), .err_clear(err_clear), .rd_strobe(rd_strobe),
    .rx_data(rx_data), .rx_ready(rx_ready), .parity_err(parity_err),
    .frame_err(frame_err), .overrun_err(overrun_err)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tick_div <= (tick_div == 3) ? 0 : tick_div + 1;
    rxc_en   <= (tick_div == 3);
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int div_of(input logic [1:0] f);
    return (f == 2'b10) ? 16 : (f == 2'b11) ? 64 : 1;
  endfunction

  task automatic wait_tick();
    do @(posedge clk); while (!rxc_en);
  endtask

  task automatic hold_bit(input logic b, input int n);
    @(negedge clk);
    rxd = b;
    for (int k = 0; k < n; k++) wait_tick();
  endtask

  task automatic send_frame(input logic [7:0] d, input logic flip_par, input logic stop_b);
    int div = div_of(mode[1:0]);
    int nb = 5 + int'(mode[3:2]);
    logic p = 1'b0;
    wait_tick();
    hold_bit(1'b0, div);
    for (int i = 0; i < nb; i++) begin
      hold_bit(d[i], div);
      p ^= d[i];
    end
    if (mode[4]) hold_bit(p ^ ~mode[5] ^ flip_par, div);
    hold_bit(stop_b, div);
    hold_bit(1'b1, 2 * div);
    @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk) rd_strobe = 1'b1;
    @(negedge clk) rd_strobe = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk) err_clear = 1'b1;
    @(negedge clk) err_clear = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ready", rx_ready, 0);
    chk("R1 flags", {parity_err, frame_err, overrun_err}, 0);
    chk("R1 data", rx_data, 8'h00);
  endtask

  task automatic t_basic_16x();
    mode = 8'hCE;
    send_frame(8'hA5, 0, 1);
    chk("R2 R3 data 16x", rx_data, 8'hA5);
    chk("R5 ready", rx_ready, 1);
    chk("R8 no frame err", frame_err, 0);
    do_read();
    chk("R6 ready cleared", rx_ready, 0);
    chk("R6 data kept", rx_data, 8'hA5);
  endtask

  task automatic t_short_64x();
    mode = 8'hC3;
    send_frame(8'hFF, 0, 1);
    chk("R2 zero padding 5 bits", rx_data, 8'h1F);
    do_read();
  endtask

  task automatic t_1x_even();
    mode = 8'h79;
    send_frame(8'h6B, 0, 1);
    chk("R4 data 1x 7 bits", rx_data, 8'h6B);
    chk("R7 even parity ok", parity_err, 0);
    do_read();
  endtask

  task automatic t_parity_err();
    mode = 8'h5E;
    send_frame(8'h3C, 1, 1);
    chk("R7 odd parity mismatch", parity_err, 1);
    chk("R7 data stored", rx_data, 8'h3C);
    do_read();
    chk("R6 read keeps parity_err", parity_err, 1);
    do_clear();
    chk("R10 clear", parity_err, 0);
  endtask

  task automatic t_frame();
    mode = 8'hCE;
    send_frame(8'h81, 0, 0);
    chk("R8 frame_err", frame_err, 1);
    chk("R8 data stored", rx_data, 8'h81);
    chk("R8 ready", rx_ready, 1);
    do_read();
    do_clear();
    chk("R10 frame cleared", frame_err, 0);
  endtask

  task automatic t_overrun();
    mode = 8'hCE;
    send_frame(8'h11, 0, 1);
    chk("R9 no overrun yet", overrun_err, 0);
    send_frame(8'h22, 0, 1);
    chk("R9 overrun_err", overrun_err, 1);
    chk("R9 new data replaces", rx_data, 8'h22);
    do_read();
    do_clear();
    chk("R10 overrun cleared", overrun_err, 0);
  endtask

  task automatic t_disabled();
    @(negedge clk) rx_enable = 1'b0;
    send_frame(8'h77, 0, 1);
    chk("R11 no ready", rx_ready, 0);
    chk("R11 data unchanged", rx_data, 8'h22);
    @(negedge clk) rx_enable = 1'b1;
  endtask

  task automatic t_glitch();
    mode = 8'hCE;
    wait_tick();
    hold_bit(1'b0, 3);
    hold_bit(1'b1, 32);
    @(negedge clk);
    chk("R3 glitch rejected", rx_ready, 0);
    send_frame(8'h5A, 0, 1);
    chk("R3 recovery after glitch", rx_data, 8'h5A);
    do_read();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    rx_enable = 1'b1;
    t_basic_16x();
    t_short_64x();
    t_1x_even();
    t_parity_err();
    t_frame();
    t_overrun();
    t_disabled();
    t_glitch();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule